// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control state machine a small CPU runs between deciding to take an interrupt and handing control to the handler's first instruction. It watches a pending hardware request (with its level) and a software-interrupt request (with its number). A hardware request is taken at an instruction boundary, or at once while a suspendable repeat instruction (block move, string store, multiply-accumulate loop) is in progress. A software request is taken at an instruction boundary.

Once an interrupt is taken, the block walks a fixed order. For hardware entries it first performs an acknowledge read at address zero, which returns the interrupt number and level, and then pulses a clear for that request. It then clears the interrupt-enable, debug and stack-select flags, pushes the flag word captured at acceptance, pushes the return PC, and loads the priority field. It then reads the handler vector and loads it into the PC. A busy output holds off instruction fetch for the whole walk.

All memory traffic uses one request/acknowledge bus. A request stays up, unchanged, until the cycle in which the acknowledge is seen.

Top module: `irq_entry_seq`

## Requirements
- R1: A hardware request is taken only when `at_boundary` or `in_string_op` is 1, and a software request only when `at_boundary` is 1. A software request wins if both are taken in the same cycle. `busy` rises on the clock edge after the accepting cycle.
- R2: A hardware request is taken only if flag bit 6 (interrupt enable) is 1 and `irq_level` is strictly greater than the priority field, flag bits 14:12. A software request ignores both conditions.
- R3: A hardware entry's first bus access is a read at address 0. Read data bits 5:0 give the number and bits 10:8 give the level. In the cycle of its acknowledge, `irq_clr` is 1 and `irq_clr_num` carries the number. A software entry does no acknowledge read and uses `swi_num`.
- R4: The first flag write equals the flags captured at acceptance with bit 6 (enable), bit 5 (debug) and bit 7 (stack select) cleared. Bit 7 is kept when a software entry has a number from 32 to 63.
- R5: Two bus writes follow. The captured flags go to SP−4 and the captured PC to SP−8, where SP is `sp_in` at acceptance. Each write's acknowledge pulses `sp_we`, with `sp_out` equal to the new, decremented pointer.
- R6: After the pushes, a second flag write loads bits 14:12 with the hardware level, or with the unchanged priority for a software entry. All other bits are as in R4.
- R7: Next comes a read at `VEC_BASE` + 4 × number. Its data, bits 19:0, is driven on `pc_out` with `pc_we` and `done` high for one cycle.
- R8: `busy` stays 1 from acceptance through the `done` cycle, is 0 the cycle after, and no request is taken while it is 1.
- R9: While `bus_req` is 1 and `bus_ack` is 0, the bus address, direction and write data hold their values into the next cycle.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pending | input | 1 | Hardware request pending |
| irq_level | input | 3 | Level of the pending hardware request |
| at_boundary | input | 1 | Current instruction completes this cycle |
| in_string_op | input | 1 | A suspendable repeat instruction is executing |
| swi_req | input | 1 | Software interrupt instruction requests entry |
| swi_num | input | 6 | Software interrupt number |
| flags_in | input | 16 | Current flag register |
| pc_in | input | 20 | Return address |
| sp_in | input | 20 | Current stack pointer |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | 32 | Bus read data, valid with acknowledge |
| irq_clr | output | 1 | Clear the acknowledged request |
| irq_clr_num | output | 6 | Number of the request to clear |
| flags_we | output | 1 | Flag register write |
| flags_out | output | 16 | Flag write value |
| sp_we | output | 1 | Stack pointer write |
| sp_out | output | 20 | Stack pointer value |
| pc_we | output | 1 | PC load |
| pc_out | output | 20 | Handler address |
| busy | output | 1 | Entry in progress, fetch held off |
| done | output | 1 | Final cycle of entry |

## Verification
The bench sweeps every level against every priority with enable both set and clear. A design with a `>=` instead of `>` would take equal-level requests, and one that ignored the enable would take masked ones. It runs all 64 software numbers, which catches a stack-select rule keyed on the wrong boundary, or a priority change on software entry. It checks the suspension case with no boundary, where a design that waits for the boundary never leaves idle. Bus acknowledges arrive with irregular stalls, so swapped push order, a wrong predecrement or a vector address not scaled by four shows up in the recorded write and read addresses.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int PCW = 20,
  parameter int FW = 16,
  parameter int NUMW = 6,
  parameter int LVLW = 3,
  parameter int I_BIT = 6,
  parameter int D_BIT = 5,
  parameter int U_BIT = 7,
  parameter int IPL_LSB = 12,
  parameter int SWI_KEEPU = 32,
  parameter logic [AW-1:0] VEC_BASE = 20'hFFD00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_pending,
  input  logic [LVLW-1:0] irq_level,
  input  logic            at_boundary,
  input  logic            in_string_op,
  input  logic            swi_req,
  input  logic [NUMW-1:0] swi_num,
  input  logic [FW-1:0]   flags_in,
  input  logic [PCW-1:0]  pc_in,
  input  logic [AW-1:0]   sp_in,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata,
  output logic            irq_clr,
  output logic [NUMW-1:0] irq_clr_num,
  output logic            flags_we,
  output logic [FW-1:0]   flags_out,
  output logic            sp_we,
  output logic [AW-1:0]   sp_out,
  output logic            pc_we,
  output logic [PCW-1:0]  pc_out,
  output logic            busy,
  output logic            done
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);
  localparam int LVL_POS = 8;

  typedef enum logic [2:0] {S_IDLE, S_ACK, S_CLR, S_PUSHF, S_PUSHPC, S_IPL, S_VEC, S_LOAD} st_t;
  st_t st;

  logic            is_sw;
  logic [NUMW-1:0] num_q;
  logic [LVLW-1:0] lvl_q;
  logic [FW-1:0]   tmp_q;
  logic [PCW-1:0]  pc_q;
  logic [AW-1:0]   sp_q;
  logic [FW-1:0]   keep_mask, fl_clr, fl_ipl;

  wire [LVLW-1:0] cur_ipl = flags_in[IPL_LSB +: LVLW];
  wire sw_ok = swi_req && at_boundary;
  wire hw_ok = irq_pending && (at_boundary || in_string_op) && flags_in[I_BIT] && (irq_level > cur_ipl);
  wire push = (st == S_PUSHF) || (st == S_PUSHPC);

  logic unused_rd;
  assign unused_rd = ^bus_rdata[DW-1:PCW];

  always_comb begin
    keep_mask = '1;
    keep_mask[I_BIT] = 1'b0;
    keep_mask[D_BIT] = 1'b0;
    if (!(is_sw && (num_q >= NUMW'(SWI_KEEPU)))) keep_mask[U_BIT] = 1'b0;
    fl_clr = tmp_q & keep_mask;
    fl_ipl = fl_clr;
    fl_ipl[IPL_LSB +: LVLW] = lvl_q;
  end

  always_comb begin
    bus_req = 1'b0;
    bus_we = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    case (st)
      S_ACK:    bus_req = 1'b1;
      S_PUSHF:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = sp_q - STEP; bus_wdata = DW'(tmp_q); end
      S_PUSHPC: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = sp_q - STEP; bus_wdata = DW'(pc_q); end
      S_VEC:    begin bus_req = 1'b1; bus_addr = VEC_BASE + (AW'(num_q) << 2); end
      default: ;
    endcase
  end

  assign irq_clr     = (st == S_ACK) && bus_ack;
  assign irq_clr_num = bus_rdata[NUMW-1:0];
  assign flags_we    = (st == S_CLR) || (st == S_IPL);
  assign flags_out   = (st == S_IPL) ? fl_ipl : fl_clr;
  assign sp_we       = push && bus_ack;
  assign sp_out      = sp_q - STEP;
  assign pc_we       = (st == S_LOAD);
  assign pc_out      = pc_q;
  assign done        = (st == S_LOAD);
  assign busy        = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      is_sw <= 1'b0;
      num_q <= '0;
      lvl_q <= '0;
      tmp_q <= '0;
      pc_q <= '0;
      sp_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (sw_ok || hw_ok) begin
          is_sw <= sw_ok;
          num_q <= swi_num;
          lvl_q <= cur_ipl;
          tmp_q <= flags_in;
          pc_q  <= pc_in;
          sp_q  <= sp_in;
          st    <= sw_ok ? S_CLR : S_ACK;
        end
        S_ACK: if (bus_ack) begin
          num_q <= bus_rdata[NUMW-1:0];
          lvl_q <= bus_rdata[LVL_POS +: LVLW];
          st    <= S_CLR;
        end
        S_CLR:    st <= S_PUSHF;
        S_PUSHF:  if (bus_ack) begin sp_q <= sp_q - STEP; st <= S_PUSHPC; end
        S_PUSHPC: if (bus_ack) begin sp_q <= sp_q - STEP; st <= S_IPL; end
        S_IPL:    st <= S_VEC;
        S_VEC:    if (bus_ack) begin pc_q <= bus_rdata[PCW-1:0]; st <= S_LOAD; end
        S_LOAD:   st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int PCW = 20,
  parameter int FW = 16,
  parameter int NUMW = 6,
  parameter int I_BIT = 6,
  parameter int D_BIT = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_req,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_ack,
  input logic            irq_clr,
  input logic            flags_we,
  input logic [FW-1:0]   flags_out,
  input logic            sp_we,
  input logic [AW-1:0]   sp_out,
  input logic            pc_we,
  input logic            busy,
  input logic            done
);
  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  assert_ack_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> bus_req && bus_ack && !bus_we && (bus_addr == '0));
  assert_flags_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> !flags_out[I_BIT] && !flags_out[D_BIT]);
  assert_push_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> bus_req && bus_we && bus_ack && (bus_addr == sp_out));
  assert_done_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pc_we && busy);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req && !flags_we && !pc_we);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW), .DW(DW), .PCW(PCW), .FW(FW), .NUMW(NUMW),
  .I_BIT(I_BIT), .D_BIT(D_BIT)) u_chk (.*);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] VB = 20'hFFD00;

  logic clk = 0, rst_n = 0;
  logic irq_pending = 0, at_boundary = 0, in_string_op = 0, swi_req = 0;
  logic [2:0] irq_level = 0;
  logic [5:0] swi_num = 0;
  logic [15:0] flags_in = 0;
  logic [19:0] pc_in = 0, sp_in = 0;
  logic bus_req, bus_we, bus_ack, irq_clr, flags_we, sp_we, pc_we, busy, done;
  logic [19:0] bus_addr, sp_out, pc_out;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0] irq_clr_num;
  logic [15:0] flags_out;

  irq_entry_seq uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [5:0] ack_num = 0;
  logic [2:0] ack_lvl = 0;
  logic rdy = 1;
  logic [7:0] lfsr = 8'h5A;

  function automatic logic [19:0] vec_of(input logic [5:0] n);
    return 20'h80012 + {6'd0, n, 8'd0};
  endfunction

  wire [19:0] voff = bus_addr - VB;
  assign bus_ack = bus_req && rdy;
  assign bus_rdata = (bus_addr == 20'd0) ? {21'd0, ack_lvl, 2'b00, ack_num}
                                         : {12'd0, vec_of(voff[7:2])};

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy  <= lfsr[0] | lfsr[2];
  end

  int wr_cnt = 0, rd_cnt = 0, fw_cnt = 0, clr_cnt = 0, done_cnt = 0;
  logic [19:0] wa [0:3];
  logic [31:0] wd [0:3];
  logic [19:0] ra [0:3];
  logic [15:0] fv [0:3];
  logic [5:0] clr_n;
  logic [19:0] pc_ld, sp_last;

  always @(posedge clk) begin
    if (bus_req && bus_ack && bus_we) begin wa[wr_cnt[1:0]] <= bus_addr; wd[wr_cnt[1:0]] <= bus_wdata; wr_cnt <= wr_cnt + 1; end
    if (bus_req && bus_ack && !bus_we) begin ra[rd_cnt[1:0]] <= bus_addr; rd_cnt <= rd_cnt + 1; end
    if (flags_we) begin fv[fw_cnt[1:0]] <= flags_out; fw_cnt <= fw_cnt + 1; end
    if (irq_clr) begin clr_n <= irq_clr_num; clr_cnt <= clr_cnt + 1; end
    if (sp_we) sp_last <= sp_out;
    if (pc_we) pc_ld <= pc_out;
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act %h exp %h", req, act, exp); end
  endtask

  task automatic entry(input bit sw, input logic [5:0] num, input logic [2:0] lvl,
                       input logic [15:0] fl, input logic [19:0] pc, input logic [19:0] sp,
                       input bit bnd, input bit strop, input bit exp_take);
    int w0, r0, f0, c0, d0;
    logic [15:0] fc, ff;
    logic [2:0] elvl;
    @(negedge clk);
    w0 = wr_cnt; r0 = rd_cnt; f0 = fw_cnt; c0 = clr_cnt; d0 = done_cnt;
    swi_req = sw; swi_num = num; irq_pending = !sw; irq_level = lvl;
    ack_num = num; ack_lvl = lvl; flags_in = fl; pc_in = pc; sp_in = sp;
    at_boundary = bnd; in_string_op = strop;
    @(negedge clk);
    swi_req = 0; irq_pending = 0; at_boundary = 0; in_string_op = 0;
    chk(busy == exp_take, "R1 R2 accept", {31'd0, busy}, {31'd0, exp_take});
    if (!exp_take || !busy) return;
    for (int i = 0; i < 200 && done_cnt == d0; i++) begin
      @(negedge clk);
      chk(busy || done_cnt != d0, "R8 busy held", {31'd0, busy}, 32'd1);
    end
    chk(!busy, "R8 busy drop", {31'd0, busy}, 32'd0);
    fc = fl & ~16'h0060;
    if (!(sw && num >= 6'd32)) fc[7] = 1'b0;
    elvl = sw ? fl[14:12] : lvl;
    ff = fc; ff[14:12] = elvl;
    chk(clr_cnt - c0 == (sw ? 0 : 1), "R3 clear count", clr_cnt - c0, sw ? 0 : 1);
    if (!sw) begin
      chk(ra[r0[1:0]] == 20'd0, "R3 ack addr", {12'd0, ra[r0[1:0]]}, 32'd0);
      chk(clr_n == num, "R3 clear num", {26'd0, clr_n}, {26'd0, num});
    end
    chk(fw_cnt - f0 == 2, "R4 R6 flag writes", fw_cnt - f0, 2);
    chk(fv[f0[1:0]] == fc, "R4 cleared flags", {16'd0, fv[f0[1:0]]}, {16'd0, fc});
    chk(fv[f0[1:0]+2'd1] == ff, "R6 ipl flags", {16'd0, fv[f0[1:0]+2'd1]}, {16'd0, ff});
    chk(wr_cnt - w0 == 2, "R5 push count", wr_cnt - w0, 2);
    chk(wa[w0[1:0]] == sp - 20'd4 && wd[w0[1:0]] == {16'd0, fl}, "R5 flag push",
        wd[w0[1:0]], {16'd0, fl});
    chk(wa[w0[1:0]+2'd1] == sp - 20'd8 && wd[w0[1:0]+2'd1] == {12'd0, pc}, "R5 pc push",
        {12'd0, wa[w0[1:0]+2'd1]}, {12'd0, sp - 20'd8});
    chk(sp_last == sp - 20'd8, "R5 sp", {12'd0, sp_last}, {12'd0, sp - 20'd8});
    chk(ra[(r0[1:0] + (sw ? 2'd0 : 2'd1))] == VB + {12'd0, num, 2'b00}, "R7 vec addr",
        {12'd0, ra[(r0[1:0] + (sw ? 2'd0 : 2'd1))]}, {12'd0, VB + {12'd0, num, 2'b00}});
    chk(pc_ld == vec_of(num), "R7 pc load", {12'd0, pc_ld}, {12'd0, vec_of(num)});
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8 act %h exp %h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_req && !flags_we && !pc_we && !done, "R8 reset idle", {31'd0, busy}, 32'd0);
    for (int n = 0; n < 64; n++)
      entry(1, 6'(n), 3'd0, 16'h70E0 | 16'(n[3:0]) | (n[0] ? 16'h0 : 16'h8000),
            20'h12340 + 20'(n), 20'h00800, 1, 0, 1);
    entry(1, 6'd40, 3'd0, 16'h2080, 20'h0ABCD, 20'h00400, 1, 0, 1);
    entry(1, 6'd3, 3'd0, 16'h20E0, 20'h0ABCD, 20'h00400, 0, 1, 0);
    for (int p = 0; p < 8; p++)
      for (int l = 0; l < 8; l++)
        for (int ie = 0; ie < 2; ie++)
          entry(0, 6'((p * 8 + l) % 64), 3'(l), {1'b0, 3'(p), 4'h5, 1'b1, ie[0], 1'b1, 5'h13},
                20'h40000 + 20'(p * 16 + l), 20'h01000 - 20'(l * 16), 1, 0, (ie == 1) && (l > p));
    entry(0, 6'd17, 3'd5, 16'h1040, 20'h11111, 20'h00600, 0, 1, 1);
    entry(0, 6'd18, 3'd5, 16'h1040, 20'h11111, 20'h00600, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busy, "R1 no stray accept", {31'd0, busy}, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule